// File: doc/BRIEF.md
# Spread-FSK Physical Frame Modulator

This block turns one fixed-length physical-layer frame into a stream of signed sine samples. Every frame is 360 bits long. A constant 32-bit synchronisation header opens it. A host fills a 38-byte payload buffer before the frame. Three trailing pause/alarm bytes close the frame and come from their own register. Each bit is mapped non-return-to-zero onto one of two carriers: a 0 picks carrier f0 and a 1 picks carrier f1. A numerically controlled oscillator produces the carrier, one sample per clock, and its phase runs on without a break when the carrier changes between bits.

Bit timing belongs to an external timing block, which supplies a one-clock bit-tick strobe. The host sets the two carrier frequencies in whole hertz, writes the payload and pulses start. The block raises busy, sends the frame one bit per tick, then drops busy and pulses done. A combinational flag reports carrier settings that are out of range or spaced too closely.

Top module: `sfsk_frame_mod`

## Requirements
- R1: A frame is 360 bits. While busy, each bit tick ends the current bit. On the clock edge that takes the tick ending bit 359, busy_o falls and done_o goes high for exactly one clock.
- R2: Bits 0 to 31 carry the header word 0xAAAA54C7, most significant bit first, so 0xAAAA comes before 0x54C7.
- R3: Bits 32 to 335 carry payload bytes 0 to 37 in ascending byte order, each byte MSB first. Payload byte k is written through pay_we_i with pay_addr_i = k, and writes to addresses above 37 have no effect.
- R4: Bits 336 to 359 carry the 24-bit tail register, bit 23 first. The register is loaded through tail_we_i and resets to zero.
- R5: While busy, the phase advances each clock by the increment of f0 when the current bit is 0 and by the increment of f1 when it is 1. bit_o shows the current bit while busy and is 0 while idle.
- R6: The phase is zero while idle and on the clock after start, and it keeps running across bit boundaries. sample_o is the table value of the phase held before each clock edge, registered, and is 0 when the block was idle before that edge.
- R7: The phase increment for a frequency f in Hz is floor(f * floor(2^40 / CLK_HZ) / 2^16), with a 24-bit phase accumulator.
- R8: The table index is the top 9 phase bits i. Take h = i mod 256 and m = min((h*(256-h)) >> 5, 2047). The sample is +m for i < 256 and -m for i >= 256, on 12 bits signed.
- R9: cfg_err_o is high when either frequency is above 148500 Hz or when |f0 - f1| < 10000 Hz. A spacing of exactly 10000 Hz is legal.
- R10: start_i is ignored while busy, including the clock of the final bit tick. bit_tick_i is ignored while idle.
- R11: After reset, busy_o, done_o, bit_o and sample_o are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a frame when idle |
| bit_tick_i | input | 1 | Bit-period strobe from timing block |
| f0_hz_i | input | 18 | Carrier for data 0, in Hz |
| f1_hz_i | input | 18 | Carrier for data 1, in Hz |
| pay_we_i | input | 1 | Payload byte write enable |
| pay_addr_i | input | 6 | Payload byte address |
| pay_data_i | input | 8 | Payload byte value |
| tail_we_i | input | 1 | Tail register write enable |
| tail_data_i | input | 24 | Tail (pause/alarm) bytes |
| cfg_err_o | output | 1 | Carrier setting illegal |
| bit_o | output | 1 | Bit being sent |
| sample_o | output | 12 | Signed sine sample |
| busy_o | output | 1 | Frame in progress |
| done_o | output | 1 | One-clock end-of-frame pulse |

## Verification
A new start request and the tick that ends the frame can arrive in the same clock. Since busy is still set on that edge, the request must be dropped and no second frame may begin. The bench raises start_i together with the 360th tick of one frame. It also raises start_i on a non-tick clock partway through another frame. A per-clock reference model then judges busy_o, done_o and sample_o, and the bit scoreboard confirms that the frame neither restarted nor stretched.

// File: rtl/sfsk_pkg.sv
package sfsk_pkg;
  localparam int HDR_BYTES   = 4;
  localparam int PAY_BYTES   = 38;
  localparam int TAIL_BYTES  = 3;
  localparam int FRAME_BYTES = HDR_BYTES + PAY_BYTES + TAIL_BYTES;
  localparam int FRAME_BITS  = FRAME_BYTES * 8;
  localparam int CNT_W       = $clog2(FRAME_BITS);
  localparam int ADDR_W      = 6;
  localparam int TAIL_W      = TAIL_BYTES * 8;
  localparam logic [HDR_BYTES*8-1:0] HDR_WORD = 32'hAAAA_54C7;
  localparam int FREQ_W      = 18;
  localparam int FREQ_MAX_HZ = 148500;
  localparam int MIN_SPAN_HZ = 10000;
endpackage

// File: rtl/sfsk_carrier_cfg.sv
module sfsk_carrier_cfg
  import sfsk_pkg::*;
#(
  parameter int CLK_HZ = 1_000_000,
  parameter int PW     = 24,
  parameter int FRAC   = 16
) (
  input  logic [FREQ_W-1:0] f0_hz_i,
  input  logic [FREQ_W-1:0] f1_hz_i,
  output logic [PW-1:0]     inc0_o,
  output logic [PW-1:0]     inc1_o,
  output logic              cfg_err_o
);
  localparam longint unsigned SCALE = (64'd1 << (PW + FRAC)) / CLK_HZ;

  logic [63:0]       prod [2];
  logic [63:0]       shf  [2];
  logic [FREQ_W-1:0] freq [2];
  logic [FREQ_W-1:0] span;

  assign freq[0] = f0_hz_i;
  assign freq[1] = f1_hz_i;

  for (genvar g = 0; g < 2; g++) begin : g_inc
    assign prod[g] = 64'(freq[g]) * SCALE;
    assign shf[g]  = prod[g] >> FRAC;
  end

  assign inc0_o = shf[0][PW-1:0];
  assign inc1_o = shf[1][PW-1:0];

  assign span = (f0_hz_i > f1_hz_i) ? (f0_hz_i - f1_hz_i) : (f1_hz_i - f0_hz_i);

  assign cfg_err_o = (span < FREQ_W'(MIN_SPAN_HZ)) ||
                     (f0_hz_i > FREQ_W'(FREQ_MAX_HZ)) ||
                     (f1_hz_i > FREQ_W'(FREQ_MAX_HZ));

  always_comb begin
    if ((f0_hz_i == f1_hz_i)) a_r9_equal_flagged: assert (cfg_err_o);
  end
endmodule

// File: rtl/sfsk_framer.sv
module sfsk_framer
  import sfsk_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              tick_i,
  input  logic              pay_we_i,
  input  logic [ADDR_W-1:0] pay_addr_i,
  input  logic [7:0]        pay_data_i,
  input  logic              tail_we_i,
  input  logic [TAIL_W-1:0] tail_data_i,
  output logic              bit_o,
  output logic              busy_o,
  output logic              done_o
);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(FRAME_BITS - 1);

  logic [7:0]        pay_q [PAY_BYTES];
  logic [TAIL_W-1:0] tail_q;
  logic              busy_q, done_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [ADDR_W-1:0] byte_idx, pay_idx;
  logic [1:0]        tail_sel;
  logic [7:0]        cur_byte;

  for (genvar g = 0; g < PAY_BYTES; g++) begin : g_pay
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                        pay_q[g] <= '0;
      else if (pay_we_i && pay_addr_i == ADDR_W'(g))      pay_q[g] <= pay_data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        tail_q <= '0;
    else if (tail_we_i) tail_q <= tail_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (start_i) begin
          busy_q <= 1'b1;
          cnt_q  <= '0;
        end
      end else if (tick_i) begin
        if (cnt_q == LAST_BIT) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign byte_idx = cnt_q[CNT_W-1:3];
  assign pay_idx  = byte_idx - ADDR_W'(HDR_BYTES);
  assign tail_sel = 2'(ADDR_W'(FRAME_BYTES - 1) - byte_idx);

  always_comb begin
    if (byte_idx < ADDR_W'(HDR_BYTES))
      cur_byte = HDR_WORD[(2'(HDR_BYTES - 1) - byte_idx[1:0]) * 8 +: 8];
    else if (byte_idx < ADDR_W'(HDR_BYTES + PAY_BYTES))
      cur_byte = pay_q[pay_idx];
    else
      cur_byte = tail_q[tail_sel * 8 +: 8];
  end

  // MSB of each byte leaves first
  assign bit_o  = busy_q & cur_byte[3'd7 - cnt_q[2:0]];
  assign busy_o = busy_q;
  assign done_o = done_q;

  a_r1_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r1_end_with_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_q) |-> done_q);
  a_r1_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST_BIT);
  a_r10_start_while_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && start_i && !tick_i) |=> (busy_q && $stable(cnt_q)));
  a_r10_tick_while_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_q && !start_i) |=> !busy_q);
endmodule

// File: rtl/sfsk_nco.sv
module sfsk_nco #(
  parameter int PW = 24,
  parameter int LB = 9,
  parameter int SW = 12
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 en_i,
  input  logic                 sel_i,
  input  logic [PW-1:0]        inc0_i,
  input  logic [PW-1:0]        inc1_i,
  output logic signed [SW-1:0] sample_o
);
  localparam int ENTRIES = 2 ** LB;
  localparam int HALF    = ENTRIES / 2;
  localparam int SH      = 2 * (LB - 1) - (SW - 1);
  localparam int PEAK    = 2 ** (SW - 1) - 1;

  function automatic logic signed [SW-1:0] lut_val(input int i);
    int h, mag;
    h   = i % HALF;
    mag = (h * (HALF - h)) >> SH;
    if (mag > PEAK) mag = PEAK;
    return (i >= HALF) ? SW'(-mag) : SW'(mag);
  endfunction

  logic signed [SW-1:0] lut [ENTRIES];
  logic [PW-1:0]        phase_q;
  logic [PW-1:0]        step;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_lut
    assign lut[g] = lut_val(g);
  end

  assign step = sel_i ? inc1_i : inc0_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q  <= '0;
      sample_o <= '0;
    end else if (en_i) begin
      phase_q  <= phase_q + step;
      sample_o <= lut[phase_q[PW-1 -: LB]];
    end else begin
      phase_q  <= '0;
      sample_o <= '0;
    end
  end

  a_r6_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (sample_o == '0));
  a_r6_first_sample_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(en_i) |=> (sample_o == '0));
endmodule

// File: rtl/sfsk_frame_mod.sv
module sfsk_frame_mod
  import sfsk_pkg::*;
#(
  parameter int CLK_HZ = 1_000_000,
  parameter int PW     = 24,
  parameter int FRAC   = 16,
  parameter int LB     = 9,
  parameter int SW     = 12
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 start_i,
  input  logic                 bit_tick_i,
  input  logic [17:0]          f0_hz_i,
  input  logic [17:0]          f1_hz_i,
  input  logic                 pay_we_i,
  input  logic [5:0]           pay_addr_i,
  input  logic [7:0]           pay_data_i,
  input  logic                 tail_we_i,
  input  logic [23:0]          tail_data_i,
  output logic                 cfg_err_o,
  output logic                 bit_o,
  output logic signed [SW-1:0] sample_o,
  output logic                 busy_o,
  output logic                 done_o
);
  logic [PW-1:0] inc0, inc1;
  logic          bit_w, busy_w;

  sfsk_carrier_cfg #(.CLK_HZ(CLK_HZ), .PW(PW), .FRAC(FRAC)) u_cfg (
    .f0_hz_i  (f0_hz_i),
    .f1_hz_i  (f1_hz_i),
    .inc0_o   (inc0),
    .inc1_o   (inc1),
    .cfg_err_o(cfg_err_o)
  );

  sfsk_framer u_framer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .tick_i     (bit_tick_i),
    .pay_we_i   (pay_we_i),
    .pay_addr_i (pay_addr_i),
    .pay_data_i (pay_data_i),
    .tail_we_i  (tail_we_i),
    .tail_data_i(tail_data_i),
    .bit_o      (bit_w),
    .busy_o     (busy_w),
    .done_o     (done_o)
  );

  sfsk_nco #(.PW(PW), .LB(LB), .SW(SW)) u_nco (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (busy_w),
    .sel_i   (bit_w),
    .inc0_i  (inc0),
    .inc1_i  (inc1),
    .sample_o(sample_o)
  );

  assign bit_o  = bit_w;
  assign busy_o = busy_w;

  a_r5_idle_bit_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !bit_o);
endmodule

// File: tb/sfsk_frame_mod_tb.sv
module sfsk_frame_mod_tb;
  localparam int CLK_P  = 10;
  localparam int CLK_HZ = 1_000_000;
  localparam int PW     = 24;
  localparam int FRAC   = 16;
  localparam int LB     = 9;
  localparam int SW     = 12;
  localparam int NBITS  = 360;
  localparam int HALF   = 2 ** (LB - 1);
  localparam int SH     = 2 * (LB - 1) - (SW - 1);
  localparam int PEAK   = 2 ** (SW - 1) - 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 0, tick = 0, pay_we = 0, tail_we = 0;
  logic [17:0] f0 = 18'd63300, f1 = 18'd74000;
  logic [5:0]  pay_addr = '0;
  logic [7:0]  pay_data = '0;
  logic [23:0] tail_data = '0;
  logic cfg_err, bit_w, busy, done;
  logic signed [SW-1:0] sample;

  int n_cmp = 0, n_bad = 0;
  bit mon_en = 0;

  logic [7:0]  pay_img [38];
  logic [23:0] tail_img = '0;
  logic        m_frame [NBITS];
  logic        exp_q [$];

  sfsk_frame_mod u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .bit_tick_i(tick),
    .f0_hz_i(f0), .f1_hz_i(f1), .pay_we_i(pay_we), .pay_addr_i(pay_addr),
    .pay_data_i(pay_data), .tail_we_i(tail_we), .tail_data_i(tail_data),
    .cfg_err_o(cfg_err), .bit_o(bit_w), .sample_o(sample), .busy_o(busy),
    .done_o(done)
  );

  always #(CLK_P/2) clk = ~clk;

  function automatic logic [PW-1:0] inc_of(input logic [17:0] f);
    longint unsigned m, p;
    m = (64'd1 << (PW + FRAC)) / CLK_HZ;
    p = (longint'(f) * m) >> FRAC;
    return p[PW-1:0];
  endfunction

  function automatic logic signed [SW-1:0] lut_of(input int i);
    int h, mag;
    h = i % HALF;
    mag = (h * (HALF - h)) >> SH;
    if (mag > PEAK) mag = PEAK;
    return (i >= HALF) ? SW'(-mag) : SW'(mag);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  // reference model, built from the requirements
  logic          m_busy, m_done;
  int            m_cnt;
  logic [PW-1:0] m_phase;
  logic signed [SW-1:0] m_sample;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy <= 0; m_done <= 0; m_cnt <= 0; m_phase <= '0; m_sample <= '0;
    end else begin
      m_done <= 0;
      if (!m_busy) begin
        if (start) begin m_busy <= 1; m_cnt <= 0; end
      end else if (tick) begin
        if (m_cnt == NBITS - 1) begin m_busy <= 0; m_done <= 1; end
        else m_cnt <= m_cnt + 1;
      end
      m_phase  <= m_busy ? m_phase + (m_frame[m_cnt] ? inc_of(f1) : inc_of(f0)) : '0;
      m_sample <= m_busy ? lut_of(int'(m_phase[PW-1 -: LB])) : '0;
    end
  end

  // monitor: samples at the falling edge
  always @(negedge clk) begin
    if (mon_en && rst_n) begin
      chk("R6 R7 R8 sample", int'(sample), int'(m_sample));
      chk("R1 busy", int'(busy), int'(m_busy));
      chk("R1 done", int'(done), int'(m_done));
      if (!m_busy) chk("R5 R10 idle bit", int'(bit_w), 0);
      if (tick && m_busy) begin
        logic e;
        e = exp_q.pop_front();
        if (m_cnt < 32)       chk("R2 header bit", int'(bit_w), int'(e));
        else if (m_cnt < 336) chk("R3 payload bit", int'(bit_w), int'(e));
        else                  chk("R4 tail bit", int'(bit_w), int'(e));
      end
    end
  end

  task automatic step();
    @(posedge clk); #(CLK_P/4);
  endtask

  task automatic write_pay(input int a, input logic [7:0] d);
    pay_we = 1; pay_addr = 6'(a); pay_data = d; step(); pay_we = 0;
    if (a < 38) pay_img[a] = d;
  endtask

  task automatic send_frame(input int gap, input int mid_start, input bit start_last);
    logic [31:0] hdr;
    hdr = 32'hAAAA_54C7;
    for (int i = 0; i < 32; i++) m_frame[i] = hdr[31 - i];
    for (int b = 0; b < 38; b++)
      for (int k = 0; k < 8; k++) m_frame[32 + b*8 + k] = pay_img[b][7 - k];
    for (int i = 0; i < 24; i++) m_frame[336 + i] = tail_img[23 - i];
    for (int i = 0; i < NBITS; i++) exp_q.push_back(m_frame[i]);
    start = 1; step(); start = 0;
    for (int i = 0; i < NBITS; i++) begin
      for (int w = 0; w < gap - 1; w++) begin
        start = (i == mid_start && w == 0);
        step();
        start = 0;
      end
      tick = 1; start = start_last && (i == NBITS - 1);
      step();
      tick = 0; start = 0;
    end
    repeat (4) step();
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin : main
    for (int i = 0; i < 38; i++) pay_img[i] = '0;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11 busy", int'(busy), 0);
    chk("R11 done", int'(done), 0);
    chk("R11 bit", int'(bit_w), 0);
    chk("R11 sample", int'(sample), 0);
    step(); rst_n = 1; mon_en = 1;

    // R9 carrier legality
    f0 = 18'd50000; f1 = 18'd59999; #1 chk("R9 span 9999", int'(cfg_err), 1);
    f1 = 18'd60000; #1 chk("R9 span 10000", int'(cfg_err), 0);
    f0 = 18'd148501; f1 = 18'd100000; #1 chk("R9 above max", int'(cfg_err), 1);
    f0 = 18'd148500; #1 chk("R9 at max", int'(cfg_err), 0);

    // R10 tick while idle
    tick = 1; step(); tick = 0; step();
    chk("R10 idle tick busy", int'(busy), 0);

    // frame 1: ramp payload, zero tail (R4 default), start mid-frame (R10)
    f0 = 18'd63300; f1 = 18'd74000;
    for (int i = 0; i < 38; i++) write_pay(i, 8'(i * 7 + 3));
    write_pay(40, 8'hFF);  // R3 out-of-range address has no effect
    send_frame(4, 100, 0);

    // frame 2: alternating payload, tail loaded, start on final tick
    f0 = 18'd132000; f1 = 18'd148500;
    for (int i = 0; i < 38; i++) write_pay(i, (i % 2) ? 8'h0F : 8'hF0);
    tail_we = 1; tail_data = 24'hA5C33C; step(); tail_we = 0; tail_img = 24'hA5C33C;
    send_frame(3, -1, 1);
    repeat (20) step();
    chk("R10 no restart", int'(busy), 0);

    // frame 3: low carriers, long bit period, continuous phase (R6)
    f0 = 18'd20000; f1 = 18'd9000;
    send_frame(7, -1, 0);
    chk("R1 queue drained", exp_q.size(), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule